// File: doc/BRIEF.md
# Software Interrupt Command Trap

This block sits on the chipset side of an I/O write bus and watches for writes to one fixed command port (address 0xB2 by default). When software writes there, the block keeps the written byte as a command value and marks the software source as pending in a status register. While any source is pending and the global enable is set, it drives an active-low system-management interrupt request toward the processor cores.

The handler finds out why it was called by reading the status register. For a software request it then reads the captured command byte. Before it resumes, it writes ones to the status bits it has dealt with. The request line rises once no enabled source is left pending.

A second interrupt source comes in on a spare input and is latched on its rising edge. A small register port gives access to the command, status and control registers. Index 0 is the command byte (read only), index 1 is status (write-one-to-clear), and index 2 is control (bit 0 is the enable). Index 3 reads as zero.

Top module: `swint_trap`

## Requirements
- R1: A write is a command-port hit only when `io_wr`=1, `io_is_io`=1 and `io_addr` equals 0x00B2. Memory writes (`io_is_io`=0) and writes to any other address leave the command and status registers unchanged.
- R2: On the clock edge that samples a hit, the byte on `io_wdata` is captured into the command register, which reads back at register index 0.
- R3: On that same edge, status bit 0 (software source) is set. Status reads at register index 1 with bit 0 for the software source and bit 1 for the external source; the upper bits read 0.
- R4: Status bit 1 is set on the edge that first samples `ext_src` high after it was low. A level held high does not set it again after it has been cleared.
- R5: Writing register index 1 clears each status bit whose data bit is 1. A 0 data bit leaves that status bit alone. If a clear and a new set of the same bit fall in the same cycle, the set wins.
- R6: `smi_n` is registered. It goes low on the edge after the one where the enable is 1 and some status bit is set, so it falls one cycle after the status bit sets.
- R7: Control register index 2, bit 0, is the global enable. When it is 0, status bits still set but `smi_n` stays high.
- R8: A command-port hit while status bit 0 is already set overwrites the command register with the new byte, and bit 0 stays set.
- R9: `smi_n` returns high one cycle after the last pending status bit is cleared. It stays low while any other bit remains set.
- R10: Reset (`rst_n`=0) clears the command register, status and enable, and drives `smi_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| io_wr | input | 1 | Write strobe of the observed bus |
| io_is_io | input | 1 | 1 = I/O space access, 0 = memory access |
| io_addr | input | 16 | Bus address |
| io_wdata | input | 8 | Bus write data |
| ext_src | input | 1 | Spare interrupt source, synchronous to `clk` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 command, 1 status, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| smi_n | output | 1 | Active-low interrupt request toward the cores |

## Verification
The bench checks the decode against near misses: an address that differs only in the upper byte, a neighbouring port, and a memory write to the right address. A decoder that compares too few bits, or that ignores the space bit, would raise a request on these. It checks the cycle-exact lag of `smi_n` behind status. A combinational output would already be low in the cycle where status has just set.

It checks the case where a clear and a new command write land together. A block where the clear wins would lose that request. It checks that an external level held high across a clear does not set bit 1 again, which a level-sensitive latch would do. Finally, it checks that clearing only one of two pending bits keeps the request asserted.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int N_SRC   = 2;
  localparam int SRC_SW  = 0;
  localparam int SRC_EXT = 1;
  localparam int REG_AW  = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD  = 2'd0,
    RA_STAT = 2'd1,
    RA_CTRL = 2'd2,
    RA_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/swint_io_decode.sv
module swint_io_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CMD_PORT = 'hB2
) (
  input  logic              io_wr,
  input  logic              io_is_io,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit
);
  // full-width compare: aliases in the upper address bits must not trigger
  always_comb begin
    hit = io_wr && io_is_io && (io_addr == CMD_PORT);
  end
endmodule

// File: rtl/swint_status.sv
module swint_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status_q
);
  logic [N-1:0] status_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new event in the same cycle as its clear is kept (set dominates)
    always_comb begin
      status_nxt[i] = set_vec[i] | (status_q[i] & ~clr_vec[i]);
    end

    p_set_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status_q[i]);

    p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr_vec[i]) |=> status_q[i]);

    p_clear_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_nxt;
  end
endmodule

// File: rtl/swint_req.sv
module swint_req #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic         enable,
  output logic         smi_n
);
  logic smi_n_nxt;

  always_comb begin
    smi_n_nxt = !(enable && (|status));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_n <= 1'b1;
    else        smi_n <= smi_n_nxt;
  end

  p_masked_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> smi_n);

  p_raise_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (|status)) |=> !smi_n);

  p_release_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> smi_n);
endmodule

// File: rtl/swint_trap.sv
module swint_trap
  import swint_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_PORT = 'hB2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_is_io,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              ext_src,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              smi_n
);
  logic              hit;
  logic              ext_d_q;
  logic              ext_rise;
  logic [N_SRC-1:0]  set_vec;
  logic [N_SRC-1:0]  clr_vec;
  logic [N_SRC-1:0]  status_q;
  logic [DATA_W-1:0] cmd_q, cmd_nxt;
  logic              en_q, en_nxt;
  logic              stat_wr, ctrl_wr;
  logic              unused_wbits;

  swint_io_decode #(.ADDR_W(ADDR_W), .CMD_PORT(CMD_PORT)) u_decode (
    .io_wr    (io_wr),
    .io_is_io (io_is_io),
    .io_addr  (io_addr),
    .hit      (hit)
  );

  // next-state logic
  always_comb begin
    ext_rise         = ext_src & ~ext_d_q;
    stat_wr          = reg_wr && (reg_sel_e'(reg_addr) == RA_STAT);
    ctrl_wr          = reg_wr && (reg_sel_e'(reg_addr) == RA_CTRL);
    set_vec          = '0;
    set_vec[SRC_SW]  = hit;
    set_vec[SRC_EXT] = ext_rise;
    clr_vec          = stat_wr ? reg_wdata[N_SRC-1:0] : '0;
    cmd_nxt          = hit ? io_wdata : cmd_q;
    en_nxt           = ctrl_wr ? reg_wdata[0] : en_q;
  end

  assign unused_wbits = ^reg_wdata[DATA_W-1:N_SRC];

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      en_q    <= 1'b0;
      ext_d_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_nxt;
      en_q    <= en_nxt;
      ext_d_q <= ext_src;
    end
  end

  swint_status #(.N(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  swint_req #(.N(N_SRC)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .enable (en_q),
    .smi_n  (smi_n)
  );

  // register read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      RA_CMD:  reg_rdata = cmd_q;
      RA_STAT: reg_rdata[N_SRC-1:0] = status_q;
      RA_CTRL: reg_rdata[0] = en_q;
      default: reg_rdata = '0;
    endcase
  end

  p_capture_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cmd_q == $past(io_wdata)));

  p_ignore_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cmd_q));

  p_sw_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q[SRC_SW]);

  p_edge_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_src) && ext_src && !status_q[SRC_EXT] && !hit && !ext_rise)
      |=> !status_q[SRC_EXT]);
endmodule

// File: tb/swint_trap_bench.sv
module swint_trap_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr, io_is_io;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        ext_src;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        smi_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  swint_trap u_swint_trap (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_is_io(io_is_io),
    .io_addr(io_addr), .io_wdata(io_wdata), .ext_src(ext_src),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smi_n(smi_n)
  );

  // {addr[15:0], is_io, data[7:0], expect_hit}
  localparam logic [25:0] VEC [6] = '{
    {16'h00B2, 1'b1, 8'h5A, 1'b1},
    {16'h00B3, 1'b1, 8'h11, 1'b0},
    {16'h00B2, 1'b0, 8'h22, 1'b0},
    {16'h01B2, 1'b1, 8'h33, 1'b0},
    {16'h00B2, 1'b1, 8'hFF, 1'b1},
    {16'h0000, 1'b1, 8'h44, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic isio, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_is_io = isio; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_cmd;
    rst_n = 1'b0; io_wr = 0; io_is_io = 0; io_addr = 0; io_wdata = 0;
    ext_src = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    reg_read(0, v); check("R10 cmd", v, 0);
    reg_read(1, v); check("R10 status", v, 0);
    reg_read(2, v); check("R10 enable", v, 0);
    check("R10 smi_n", smi_n, 1);

    // R1 R2 R3: decode table
    exp_cmd = 8'h00;
    for (int i = 0; i < 6; i++) begin
      reg_write(1, 8'h03);
      io_write(VEC[i][25:10], VEC[i][9], VEC[i][8:1]);
      if (VEC[i][0]) exp_cmd = VEC[i][8:1];
      reg_read(1, v); check("R1/R3 status bit0", v, {7'd0, VEC[i][0]});
      reg_read(0, v); check("R2 command byte", v, exp_cmd);
    end

    // R7: enable clear -> status set, smi_n high
    reg_write(1, 8'h03);
    io_write(16'h00B2, 1, 8'h10);
    repeat (2) @(negedge clk);
    reg_read(1, v); check("R7 status sets while masked", v, 1);
    check("R7 smi_n masked", smi_n, 1);
    reg_write(2, 8'h01);
    reg_read(2, v); check("R7 enable readback", v, 1);
    check("R6 smi_n lags enable", smi_n, 1);
    @(negedge clk);
    check("R6 smi_n low after enable", smi_n, 0);

    // R6: registered lag behind status
    reg_write(1, 8'h01);
    @(negedge clk);
    check("R9 smi_n released", smi_n, 1);
    io_write(16'h00B2, 1, 8'h21);
    reg_read(1, v); check("R3 status set", v, 1);
    check("R6 smi_n not yet low", smi_n, 1);
    @(negedge clk);
    check("R6 smi_n low", smi_n, 0);

    // R8: overwrite while pending
    io_write(16'h00B2, 1, 8'h9C);
    reg_read(0, v); check("R8 command overwritten", v, 8'h9C);
    reg_read(1, v); check("R8 status stays", v, 1);
    check("R8 smi_n stays low", smi_n, 0);

    // R5: writing 0 does nothing, 1 clears
    reg_write(1, 8'h00);
    reg_read(1, v); check("R5 zero write ignored", v, 1);
    reg_write(1, 8'h01);
    reg_read(1, v); check("R5 W1C clears", v, 0);
    check("R9 smi_n one cycle late", smi_n, 0);
    @(negedge clk);
    check("R9 smi_n high after clear", smi_n, 1);

    // R5: set beats clear in the same cycle
    io_write(16'h00B2, 1, 8'h01);
    @(negedge clk);
    io_wr = 1; io_is_io = 1; io_addr = 16'h00B2; io_wdata = 8'h77;
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'h01;
    @(negedge clk);
    io_wr = 0; reg_wr = 0;
    reg_read(1, v); check("R5 set wins over clear", v, 1);
    reg_read(0, v); check("R2 command on collision", v, 8'h77);
    reg_write(1, 8'h03);

    // R4: external rising edge
    @(negedge clk); ext_src = 1;
    @(negedge clk);
    reg_read(1, v); check("R4 ext sets bit1", v, 2);
    reg_write(1, 8'h02);
    repeat (3) @(negedge clk);
    reg_read(1, v); check("R4 held level no reset", v, 0);
    ext_src = 0;
    @(negedge clk); ext_src = 1;
    @(negedge clk);
    reg_read(1, v); check("R4 new edge sets", v, 2);

    // R9: partial clear keeps request
    io_write(16'h00B2, 1, 8'h42);
    @(negedge clk);
    reg_read(1, v); check("R3 both pending", v, 3);
    reg_write(1, 8'h01);
    repeat (2) @(negedge clk);
    check("R9 smi_n held by bit1", smi_n, 0);
    reg_write(1, 8'h02);
    @(negedge clk);
    check("R9 smi_n released all clear", smi_n, 1);

    // R10: reset mid-operation
    ext_src = 0;
    io_write(16'h00B2, 1, 8'hAB);
    @(negedge clk);
    check("R6 smi_n low before reset", smi_n, 0);
    rst_n = 0;
    #2;
    reg_read(0, v); check("R10 cmd cleared", v, 0);
    reg_read(1, v); check("R10 status cleared", v, 0);
    reg_read(2, v); check("R10 enable cleared", v, 0);
    check("R10 smi_n high", smi_n, 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule